// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block keeps the fetch address state for a 32-bit RISC pipeline that has one architectural branch delay slot. It holds three registers: the address being executed, the address that follows it, and the address executed before it. Each instruction presents its control-flow intent on the inputs while `advance` is high. This intent can be a relative branch or jump with a word offset, a jump to a register value, a link request, or a return from an exception. The sequencer then steps the registers on that clock edge.

A redirect never replaces the current successor. It replaces the address that comes after the successor. The instruction in the slot after a taken branch therefore always runs before the target. An output flag marks the slot instruction while it is current. A return from exception overrides any redirect and resumes at the saved exception address at once. In the same cycle it pulses a strobe so that the saved status word can be written back. A stall input freezes every register and masks the strobes.

Top module: `dslot_pc_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `pc_o` and `pc_prev_o` are 0, `pc_next_o` is 4 and `in_slot_o` is 0.
- R2: On a clock edge with `advance` high, `stall` low, `rfe` low and no redirect, `pc_prev_o` takes the old `pc_o`, `pc_o` takes the old `pc_next_o`, and `pc_next_o` becomes the old `pc_next_o` plus 4.
- R3: A relative redirect (`br_uncond`, or a conditional branch that is taken) sets `pc_next_o` to the old `pc_o` plus the `offset` field sign-extended from bit 25 and multiplied by 4. `pc_o` still takes the old `pc_next_o`, so the slot instruction comes first.
- R4: With `jr_valid` high, `pc_next_o` takes `jr_target` unchanged. This has priority over a relative target presented in the same cycle.
- R5: A conditional branch (`br_cond` high) is taken only when `flag_in` equals `br_sense`. Sense 1 branches on a set flag and sense 0 branches on a clear flag. Otherwise the step is sequential as in R2.
- R6: `link_we_o` is high exactly while `link_req` and `advance` are high and `stall` is low. `link_val_o` always equals `pc_o` plus 8.
- R7: On an advance with `rfe` high, `pc_o` takes `epc_in` and `pc_next_o` takes `epc_in` plus 4. Any redirect in the same cycle is ignored. `sr_restore_o` is high in that cycle and `sr_val_o` carries `esr_in`.
- R8: While `stall` is high, no register changes and `link_we_o` and `sr_restore_o` stay low, whatever the other inputs are.
- R9: While `advance` is low, no register changes.
- R10: `in_slot_o` is 1 after an advance that redirected without `rfe`, and 0 after any other advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes all state and masks strobes |
| advance | input | 1 | Current instruction retires on this edge |
| br_cond | input | 1 | Conditional relative branch |
| br_sense | input | 1 | Branch when flag equals this value |
| br_uncond | input | 1 | Unconditional relative jump |
| offset | input | 26 | Signed word offset for relative targets |
| jr_valid | input | 1 | Jump to register value |
| jr_target | input | 32 | Register value for indirect jump |
| link_req | input | 1 | Instruction writes the link register |
| flag_in | input | 1 | Current compare flag |
| rfe | input | 1 | Return from exception |
| epc_in | input | 32 | Saved exception address |
| esr_in | input | 32 | Saved status word |
| pc_o | output | 32 | Address of current instruction |
| pc_next_o | output | 32 | Address that follows it |
| pc_prev_o | output | 32 | Address of previous instruction |
| in_slot_o | output | 1 | Current instruction is a delay slot |
| link_we_o | output | 1 | Link register write strobe |
| link_val_o | output | 32 | Link value |
| sr_restore_o | output | 1 | Status restore strobe |
| sr_val_o | output | 32 | Status value to restore |

## Verification
The strobes and the link value are combinational. They are due in the same cycle as their inputs, so the bench checks them 1 ns after driving each instruction, before the edge. The three address registers and the slot flag change on the edge on which the instruction advances. The bench checks them at the falling edge that follows, against a bench model that steps once per edge. A redirect shows up in `pc_o` only after a second advance, and the bench counts that lag in its model rather than sampling one edge early.

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq #(
  parameter int AW   = 32,
  parameter int OFFW = 26,
  parameter int SRW  = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            advance,
  input  logic            br_cond,
  input  logic            br_sense,
  input  logic            br_uncond,
  input  logic [OFFW-1:0] offset,
  input  logic            jr_valid,
  input  logic [AW-1:0]   jr_target,
  input  logic            link_req,
  input  logic            flag_in,
  input  logic            rfe,
  input  logic [AW-1:0]   epc_in,
  input  logic [SRW-1:0]  esr_in,
  output logic [AW-1:0]   pc_o,
  output logic [AW-1:0]   pc_next_o,
  output logic [AW-1:0]   pc_prev_o,
  output logic            in_slot_o,
  output logic            link_we_o,
  output logic [AW-1:0]   link_val_o,
  output logic            sr_restore_o,
  output logic [SRW-1:0]  sr_val_o
);
  localparam logic [AW-1:0] WORD = AW'(4);
  localparam logic [AW-1:0] PAIR = AW'(8);

  logic [AW-1:0] pc_q, npc_q, prev_q;
  logic          slot_q;
  logic          go, hit, take;
  logic [AW-1:0] rel, tgt;

  assign go   = advance & ~stall;
  assign hit  = br_cond & (flag_in == br_sense);
  assign take = jr_valid | br_uncond | hit;
  assign rel  = pc_q + ({{(AW-OFFW){offset[OFFW-1]}}, offset} << 2);
  assign tgt  = jr_valid ? jr_target : rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      npc_q  <= RESET_PC + WORD;
      prev_q <= RESET_PC;
      slot_q <= 1'b0;
    end else if (go) begin
      prev_q <= pc_q;
      if (rfe) begin
        pc_q   <= epc_in;
        npc_q  <= epc_in + WORD;
        slot_q <= 1'b0;
      end else begin
        pc_q   <= npc_q;
        npc_q  <= take ? tgt : npc_q + WORD;
        slot_q <= take;
      end
    end
  end

  assign pc_o         = pc_q;
  assign pc_next_o    = npc_q;
  assign pc_prev_o    = prev_q;
  assign in_slot_o    = slot_q;
  assign link_we_o    = go & link_req;
  assign link_val_o   = pc_q + PAIR;
  assign sr_restore_o = go & rfe;
  assign sr_val_o     = esr_in;

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc_q) && $stable(npc_q) && $stable(prev_q) && $stable(slot_q)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(pc_q) && $stable(npc_q) && $stable(prev_q)));

  assert_prev_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !stall) |=> prev_q == $past(pc_q));

  assert_slot_runs_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !stall && !rfe) |=> pc_q == $past(npc_q));

  assert_rfe_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !stall && rfe) |=> (pc_q == $past(epc_in) && !slot_q));

  assert_no_strobe_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!link_we_o && !sr_restore_o));
endmodule

// File: tb/dslot_pc_seq_test.sv
`timescale 1ns/1ps
module dslot_pc_seq_test;
  logic clk = 0, rst_n = 0;
  logic stall = 0, advance = 0, br_cond = 0, br_sense = 0, br_uncond = 0;
  logic [25:0] offset = '0;
  logic jr_valid = 0, link_req = 0, flag_in = 0, rfe = 0;
  logic [31:0] jr_target = '0, epc_in = '0, esr_in = '0;
  logic [31:0] pc_o, pc_next_o, pc_prev_o, link_val_o, sr_val_o;
  logic in_slot_o, link_we_o, sr_restore_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_pc, m_npc, m_prev;
  logic m_slot;

  always #2.5 clk = ~clk;

  dslot_pc_seq uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rel_tgt(input logic [31:0] pc, input logic [25:0] off);
    logic signed [31:0] s;
    s = 32'(signed'(off));
    return pc + 32'(s * 4);
  endfunction

  task automatic clear_in();
    stall = 0; advance = 0; br_cond = 0; br_sense = 0; br_uncond = 0;
    offset = '0; jr_valid = 0; link_req = 0; flag_in = 0; rfe = 0;
  endtask

  // inputs already driven after a falling edge
  task automatic step();
    logic go, take;
    logic [31:0] t;
    #1;
    go = advance && !stall;
    chk("R6 link_we", 32'(link_we_o), 32'(go && link_req));
    chk("R6 link_val", link_val_o, m_pc + 8);
    chk("R7/R8 sr_restore", 32'(sr_restore_o), 32'(go && rfe));
    if (go && rfe) chk("R7 sr_val", sr_val_o, esr_in);
    take = jr_valid || br_uncond || (br_cond && (flag_in == br_sense));
    t = jr_valid ? jr_target : rel_tgt(m_pc, offset);
    @(posedge clk);
    if (go) begin
      m_prev = m_pc;
      if (rfe) begin m_pc = epc_in; m_npc = epc_in + 4; m_slot = 0; end
      else begin m_pc = m_npc; m_npc = take ? t : m_npc + 4; m_slot = take; end
    end
    @(negedge clk);
    chk("R2/R7/R8/R9 pc", pc_o, m_pc);
    chk("R3/R4/R5 next", pc_next_o, m_npc);
    chk("R2 prev", pc_prev_o, m_prev);
    chk("R10 slot", 32'(in_slot_o), 32'(m_slot));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_pc = 0; m_npc = 4; m_prev = 0; m_slot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc_o, 0); chk("R1 next", pc_next_o, 4);
    chk("R1 prev", pc_prev_o, 0); chk("R1 slot", 32'(in_slot_o), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pc after release", pc_o, 0);

    // R2 sequential
    clear_in(); advance = 1; step(); step();
    // R3 negative offset branch, then delay slot with forward jump (branch in slot)
    clear_in(); advance = 1; br_uncond = 1; offset = 26'h3ff_fffe; link_req = 1; step();
    clear_in(); advance = 1; br_uncond = 1; offset = 26'h1ff_ffff; step();
    clear_in(); advance = 1; step(); step();
    // R5 both senses, taken and not taken
    clear_in(); advance = 1; br_cond = 1; br_sense = 1; flag_in = 0; offset = 26'd10; step();
    clear_in(); advance = 1; br_cond = 1; br_sense = 0; flag_in = 0; offset = 26'd10; step();
    clear_in(); advance = 1; br_cond = 1; br_sense = 0; flag_in = 1; offset = 26'd3; step();
    // R4 indirect wins over relative
    clear_in(); advance = 1; jr_valid = 1; jr_target = 32'h0000_8000; br_uncond = 1; offset = 26'd5; step();
    clear_in(); advance = 1; step();
    // R7 rfe overrides a jump
    clear_in(); advance = 1; rfe = 1; epc_in = 32'h0000_1234; esr_in = 32'hcafe_0001; jr_valid = 1; jr_target = 32'h40; step();
    // R8 stall with everything asserted
    clear_in(); advance = 1; stall = 1; rfe = 1; link_req = 1; br_uncond = 1; offset = 26'd7; step();
    // R9 idle
    clear_in(); br_uncond = 1; offset = 26'd9; link_req = 1; step();

    for (int i = 0; i < 3000; i++) begin
      int k;
      clear_in();
      advance = ($urandom % 8) != 0;
      stall = ($urandom % 7) == 0;
      rfe = ($urandom % 19) == 0;
      k = $urandom % 5;
      br_cond = (k == 1); br_uncond = (k == 2); jr_valid = (k == 3);
      br_sense = $urandom; flag_in = $urandom; link_req = $urandom;
      offset = 26'($urandom); jr_target = $urandom & 32'hffff_fffc;
      epc_in = $urandom & 32'hffff_fffc; esr_in = $urandom;
      step();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule